// File: doc/BRIEF.md
# Hardware LIFO Register Stack

This block is a last-in first-out store of 64 data words held in registers and addressed by a 6-bit stack pointer. A producer offers words on a valid/ready input channel, and a consumer asks for the most recent word with a pop request strobe. Two plain status pins report when the stack is full and when it is empty. Single-cycle pulses report a push refused because the stack is full and a pop refused because it is empty.

The pointer moves in a fixed order. An accepted push first advances the pointer and then stores the word at the new position. An accepted pop first reads the word at the current position and then steps the pointer back. Starting from reset with the pointer at zero, the first word lands at location 1. The 64th word lands at location 0, and the pointer returning to zero marks the stack full. A pop that brings the pointer back to zero marks the stack empty.

Back-pressure works as follows. `push_ready` is low exactly while the stack is full. A word moves only in a cycle with `push_valid` high, `push_ready` high and `pop_req` low. Popped data has no back-pressure: it appears for exactly one cycle, one cycle after the request.

Top module: `lifo_regstack`

## Requirements
- R1: After reset the stack is empty (`empty`=1, `full`=0, `push_ready`=1), and `pop_valid`, `overflow` and `underflow` are 0.
- R2: A push accepted in cycle k (`push_valid`=1, `pop_req`=0, not full) clears `empty` from cycle k+1. It advances the pointer by one and stores `push_data` at the advanced position.
- R3: The 64th accepted push counted from empty wraps the 6-bit pointer to 0 and sets `full`, which drives `push_ready` low.
- R4: A pop accepted in cycle k (`pop_req`=1, `push_valid`=0, not empty) drives `pop_valid`=1 in cycle k+1 with `pop_data` equal to the word at the pointer. It then steps the pointer back by one and clears `full`.
- R5: A pop that leaves the pointer at 0 sets `empty`.
- R6: A push offered while full (with `pop_req`=0) changes no stored word, pointer or flag, and raises `overflow` for one cycle in the next cycle.
- R7: A pop requested while empty (with `push_valid`=0) changes nothing, keeps `pop_valid` low, and raises `underflow` for one cycle in the next cycle.
- R8: `push_valid` and `pop_req` high in the same cycle form a no-operation: nothing is stored or read, the flags hold, and no pulse is raised.
- R9: Words come back in the reverse of the order they were pushed, under any interleaving of pushes and pops.
- R10: `full` and `empty` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer offers `push_data` |
| push_ready | output | 1 | Stack can take a word (not full) |
| push_data | input | 16 | Word to push |
| pop_req | input | 1 | Request to pop the top word |
| pop_valid | output | 1 | `pop_data` holds a popped word this cycle |
| pop_data | output | 16 | Popped word |
| full | output | 1 | All 64 locations hold data |
| empty | output | 1 | No location holds data |
| overflow | output | 1 | One-cycle pulse: a push was refused because the stack was full |
| underflow | output | 1 | One-cycle pulse: a pop was refused because the stack was empty |

## Verification
Some properties are checked on every cycle: the pointer moves one step up on a push and one step down on a pop, the flags never clash, a refused request leaves the pointer still and pulses its error pin, and an accepted pop is followed by a valid output. Other behaviour shows only through the scenarios, because it concerns the content of the store: that a pop returns the word most recently pushed, that the 64th push reaches location 0 and is read back first after filling, and that refused and colliding requests corrupt no stored word. A queue-based model in the bench covers these by comparing every output on every clock.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PUSH  = 2'b01,
    OP_POP   = 2'b10,
    OP_CLASH = 2'b11
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    return stk_op_e'({pop, push});
  endfunction
endpackage

// File: rtl/lifo_ptr_ctrl.sv
module lifo_ptr_ctrl
  import lifo_stack_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic [PTR_W-1:0] wr_addr,
  output logic             wr_en,
  output logic [PTR_W-1:0] rd_addr,
  output logic             rd_en,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);
  logic [PTR_W-1:0] sp, sp_up, sp_down;
  stk_op_e          op;

  always_comb begin
    op      = decode_op(push_req, pop_req);
    sp_up   = sp + 1'b1;
    sp_down = sp - 1'b1;
    wr_en   = (op == OP_PUSH) && !full;
    rd_en   = (op == OP_POP) && !empty;
    wr_addr = sp_up;
    rd_addr = sp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= (op == OP_PUSH) && full;
      underflow <= (op == OP_POP) && empty;
      if (wr_en) begin
        sp    <= sp_up;
        full  <= (sp_up == '0);
        empty <= 1'b0;
      end else if (rd_en) begin
        sp    <= sp_down;
        empty <= (sp_down == '0);
        full  <= 1'b0;
      end
    end
  end

  AST_PUSH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sp == $past(sp) + 1'b1) && !empty); // R2
  AST_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (sp == '0)); // R3
  AST_POP_RETREATS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (sp == $past(sp) - 1'b1) && !full); // R4
  AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (sp == '0)); // R5
  AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && full) |=> overflow && $stable(sp) && full); // R6
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && empty) |=> underflow && $stable(sp) && empty); // R7
  AST_CLASH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> $stable(sp) && !overflow && !underflow); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R10
endmodule

// File: rtl/lifo_word_store.sv
module lifo_word_store #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= cells[rd_addr];
    end
  end

  AST_POP_OUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R4
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R7
endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow
);
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic             wr_en, rd_en;

  lifo_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_valid),
    .pop_req   (pop_req),
    .wr_addr   (wr_addr),
    .wr_en     (wr_en),
    .rd_addr   (rd_addr),
    .rd_en     (rd_en),
    .full      (full),
    .empty     (empty),
    .overflow  (overflow),
    .underflow (underflow)
  );

  lifo_word_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (push_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (pop_valid),
    .rd_data  (pop_data)
  );

  assign push_ready = !full;

  AST_READY_TRACKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready != full); // R3
endmodule

// File: tb/sim_lifo_regstack.sv
module sim_lifo_regstack;
  localparam int DW = 16;
  localparam int CAP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          pop_req = 1'b0;
  logic          push_ready, pop_valid, full, empty, overflow, underflow;
  logic [DW-1:0] pop_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [$];
  logic          exp_pv, exp_ovf, exp_unf;
  logic [DW-1:0] exp_pd;

  always #2.5 clk = ~clk;

  lifo_regstack u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_req(pop_req), .pop_valid(pop_valid),
    .pop_data(pop_data), .full(full), .empty(empty), .overflow(overflow),
    .underflow(underflow)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " R3 full"}, DW'(full), DW'(model.size() == CAP));
    check({tag, " R5 empty"}, DW'(empty), DW'(model.size() == 0));
    check({tag, " R3 push_ready"}, DW'(push_ready), DW'(model.size() != CAP));
    check({tag, " R10 flags"}, DW'(full && empty), '0);
    check({tag, " R4 pop_valid"}, DW'(pop_valid), DW'(exp_pv));
    check({tag, " R6 overflow"}, DW'(overflow), DW'(exp_ovf));
    check({tag, " R7 underflow"}, DW'(underflow), DW'(exp_unf));
    if (exp_pv) check({tag, " R9 pop_data"}, pop_data, exp_pd);
  endtask

  task automatic cyc(logic pv, logic pr, logic [DW-1:0] d, string tag);
    @(negedge clk);
    push_valid = pv;
    pop_req    = pr;
    push_data  = d;
    exp_pv = 1'b0; exp_ovf = 1'b0; exp_unf = 1'b0;
    if (pv && !pr) begin
      if (model.size() == CAP) exp_ovf = 1'b1;
      else model.push_back(d);
    end else if (pr && !pv) begin
      if (model.size() == 0) exp_unf = 1'b1;
      else begin
        exp_pv = 1'b1;
        exp_pd = model.pop_back();
      end
    end
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  initial begin
    #900000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    exp_pv = 1'b0; exp_ovf = 1'b0; exp_unf = 1'b0; exp_pd = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset");

    // R2 R4 R9: short push/pop run
    cyc(1, 0, 16'h1111, "R2 push");
    cyc(1, 0, 16'h2222, "R2 push");
    cyc(1, 0, 16'h3333, "R2 push");
    cyc(0, 0, 16'h0000, "idle");
    cyc(0, 1, 16'h0000, "R4 pop");
    cyc(0, 1, 16'h0000, "R4 pop");
    cyc(0, 1, 16'h0000, "R5 pop to empty");
    // R7: pop on empty
    cyc(0, 1, 16'h0000, "R7 underflow");
    cyc(0, 0, 16'h0000, "R7 after");
    // R8 while empty
    cyc(1, 1, 16'hDEAD, "R8 clash empty");
    // R3: fill to 64
    for (int i = 0; i < CAP; i++) cyc(1, 0, DW'(16'hA000 + i), "R3 fill");
    // R6: push on full must not corrupt
    cyc(1, 0, 16'hBAD0, "R6 overflow");
    cyc(1, 0, 16'hBAD1, "R6 overflow");
    cyc(1, 1, 16'hBAD2, "R8 clash full");
    // drain all: first word back is the 64th (location 0)
    for (int i = 0; i < CAP; i++) cyc(0, 1, '0, "R9 drain");
    cyc(0, 1, '0, "R7 underflow after drain");
    // random interleaving
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      cyc(r < 5, (r >= 4) && (r < 9), DW'($urandom), "R9 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule